// File: doc/BRIEF.md
# Strip-Mining Loop Sequencer

This block walks an element-wise array operation of any length through a vector unit whose per-pass capacity is only known at run time. Software hands it a total element count, the base addresses of two source arrays and one destination array, the current maximum elements per pass, and an element size code. The sequencer then emits a series of pass descriptors. Each descriptor carries the pass length and the three addresses at which that pass starts.

Each pass length is the smaller of the elements still outstanding and the capacity. The final pass therefore carries a short length, and no separate tail loop is needed. After each descriptor is taken, the outstanding count drops by the pass length. Every address moves forward by the pass length times the element size in bytes. When nothing is left, the block pulses `doneOut` for one cycle and becomes idle again.

Top module: `stripSeq`

## Requirements
- R1: When `idle` is high and `startReq` is sampled high, the block captures `totalCount`, the three base addresses, `vlMax` and `sizeCode`. A start while the block is busy is ignored, and later changes to these inputs do not affect the job in progress. Out of reset, `idle`=1, `passValid`=0 and `doneOut`=0, and no two of these three are high together.
- R2: Every pass length `passVl` equals min(outstanding count, captured `vlMax`) and is never zero (`vlMax` is assumed nonzero).
- R3: After each accepted descriptor (`passValid` and `passReady` both high at a clock edge), the outstanding count drops by `passVl`. Passes continue until it reaches zero, so the sum of pass lengths equals the count. A count of 6 with a capacity of 4 gives passes of 4 and then 2.
- R4: The first descriptor carries the three base addresses. After each accepted descriptor, every address grows by `passVl` shifted left by `sizeCode`, where code 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes per element.
- R5: While `passValid` is high and `passReady` is low, the descriptor (`passVl` and all three addresses) stays unchanged and `passValid` stays high.
- R6: A start with `totalCount`=0 issues no descriptor. `doneOut` is high in the cycle right after the start edge.
- R7: `doneOut` is high for exactly one cycle, right after the edge that accepts the last descriptor. `idle` is high in the next cycle.
- R8: `passValid` first rises two cycles after the start edge. After a non-final acceptance, `passValid` is low for one cycle and then rises with the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start request, taken only while idle |
| totalCount | input | CNT_W | Total number of elements in the job |
| srcABase | input | ADDR_W | Base byte address of the first source array |
| srcBBase | input | ADDR_W | Base byte address of the second source array |
| dstBase | input | ADDR_W | Base byte address of the destination array |
| vlMax | input | VL_W | Maximum elements per pass (nonzero) |
| sizeCode | input | 2 | log2 of the element size in bytes |
| idle | output | 1 | Block is idle and will accept a start |
| passValid | output | 1 | Pass descriptor is valid |
| passReady | input | 1 | Consumer accepts the descriptor |
| passVl | output | VL_W | Elements in this pass |
| passSrcA | output | ADDR_W | First source address for this pass |
| passSrcB | output | ADDR_W | Second source address for this pass |
| passDst | output | ADDR_W | Destination address for this pass |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle, and both are provoked on purpose.

The first is the acceptance of the final descriptor, which also drives the outstanding count to zero. With `passReady` held high, random or alternating, the bench checks that this edge produces the done pulse and no further descriptor.

The second is a start request that arrives while a job is still being accepted. The bench holds `startReq` high and scrambles `totalCount` for the whole job. It then judges that the job's pass count and length total still match the originally captured count.

A behavioural model compares every output on every cycle.

// File: rtl/stripSeqPkg.sv
package stripSeqPkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT_ACK,
    S_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture job inputs
    logic calc;     // compute pass length
    logic advance;  // consume a pass
  } pathCtrl_t;

endpackage

// File: rtl/stripSeqPath.sv
module stripSeqPath
  import stripSeqPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pathCtrl_t             ctl,
  input  logic [CNT_W-1:0]      totalCount,
  input  logic [ADDR_W-1:0]     srcABase,
  input  logic [ADDR_W-1:0]     srcBBase,
  input  logic [ADDR_W-1:0]     dstBase,
  input  logic [VL_W-1:0]       vlMax,
  input  logic [1:0]            sizeCode,
  output logic [VL_W-1:0]       vlOut,
  output logic [3*ADDR_W-1:0]   ptrOut,
  output logic                  startZero,
  output logic                  lastPass
);

  localparam int NPTR = 3;

  logic [CNT_W-1:0]       remReg;
  logic [VL_W-1:0]        vlMaxReg;
  logic [VL_W-1:0]        vlReg;
  logic [1:0]             sizeReg;
  logic [ADDR_W-1:0]      stride;
  logic [NPTR*ADDR_W-1:0] baseBus;

  assign baseBus   = {dstBase, srcBBase, srcABase};
  assign stride    = ADDR_W'(vlReg) << sizeReg;
  assign startZero = (totalCount == '0);
  assign lastPass  = (remReg == CNT_W'(vlReg));
  assign vlOut     = vlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg   <= '0;
      vlMaxReg <= '0;
      sizeReg  <= '0;
      vlReg    <= '0;
    end else begin
      if (ctl.load) begin
        remReg   <= totalCount;
        vlMaxReg <= vlMax;
        sizeReg  <= sizeCode;
      end else if (ctl.advance) begin
        remReg <= remReg - CNT_W'(vlReg);
      end
      if (ctl.calc) begin
        if (remReg < CNT_W'(vlMaxReg)) vlReg <= VL_W'(remReg);
        else                           vlReg <= vlMaxReg;
      end
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    logic [ADDR_W-1:0] ptrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            ptrQ <= '0;
      else if (ctl.load)    ptrQ <= baseBus[p*ADDR_W +: ADDR_W];
      else if (ctl.advance) ptrQ <= ptrQ + stride;
    end
    assign ptrOut[p*ADDR_W +: ADDR_W] = ptrQ;
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (CNT_W'(vlReg) <= remReg));

  // R2
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (vlReg != '0 && vlReg <= vlMaxReg));

endmodule

// File: rtl/stripSeqCtrl.sv
module stripSeqCtrl
  import stripSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      passReady,
  input  logic      startZero,
  input  logic      lastPass,
  output pathCtrl_t ctl,
  output logic      passValid,
  output logic      doneOut,
  output logic      idle
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          ctl.load  = 1'b1;
          nextState = startZero ? S_DONE : S_ISSUE;
        end
      end
      S_ISSUE: begin
        ctl.calc  = 1'b1;
        nextState = S_WAIT_ACK;
      end
      S_WAIT_ACK: begin
        if (passReady) begin
          ctl.advance = 1'b1;
          nextState   = lastPass ? S_DONE : S_ISSUE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign passValid = (state == S_WAIT_ACK);
  assign doneOut   = (state == S_DONE);
  assign idle      = (state == S_IDLE);

  // R6
  zero_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && startReq && startZero) |=> (doneOut && !passValid));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && idle));

  // R8
  gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passValid && passReady) |=> !passValid);

endmodule

// File: rtl/stripSeq.sv
module stripSeq
  import stripSeqPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  totalCount,
  input  logic [ADDR_W-1:0] srcABase,
  input  logic [ADDR_W-1:0] srcBBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [VL_W-1:0]   vlMax,
  input  logic [1:0]        sizeCode,
  output logic              idle,
  output logic              passValid,
  input  logic              passReady,
  output logic [VL_W-1:0]   passVl,
  output logic [ADDR_W-1:0] passSrcA,
  output logic [ADDR_W-1:0] passSrcB,
  output logic [ADDR_W-1:0] passDst
  ,
  output logic              doneOut
);

  pathCtrl_t           ctl;
  logic                startZero;
  logic                lastPass;
  logic [3*ADDR_W-1:0] ptrBus;

  stripSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .passReady (passReady),
    .startZero (startZero),
    .lastPass  (lastPass),
    .ctl       (ctl),
    .passValid (passValid),
    .doneOut   (doneOut),
    .idle      (idle)
  );

  stripSeqPath #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .VL_W   (VL_W)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .totalCount (totalCount),
    .srcABase   (srcABase),
    .srcBBase   (srcBBase),
    .dstBase    (dstBase),
    .vlMax      (vlMax),
    .sizeCode   (sizeCode),
    .vlOut      (passVl),
    .ptrOut     (ptrBus),
    .startZero  (startZero),
    .lastPass   (lastPass)
  );

  assign passSrcA = ptrBus[0*ADDR_W +: ADDR_W];
  assign passSrcB = ptrBus[1*ADDR_W +: ADDR_W];
  assign passDst  = ptrBus[2*ADDR_W +: ADDR_W];

  // R5
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passValid && !passReady) |=> (passValid && $stable(passVl) &&
      $stable(passSrcA) && $stable(passSrcB) && $stable(passDst)));

  // R1
  out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idle, passValid, doneOut}));

endmodule

// File: tb/test_stripSeq.sv
module test_stripSeq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 32;
  localparam int VL_W   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [CNT_W-1:0]  totalCount = '0;
  logic [ADDR_W-1:0] srcABase = '0;
  logic [ADDR_W-1:0] srcBBase = '0;
  logic [ADDR_W-1:0] dstBase = '0;
  logic [VL_W-1:0]   vlMax = 8'd1;
  logic [1:0]        sizeCode = '0;
  logic              idle;
  logic              passValid;
  logic              passReady = 1'b0;
  logic [VL_W-1:0]   passVl;
  logic [ADDR_W-1:0] passSrcA, passSrcB, passDst;
  logic              doneOut;

  int checks = 0;
  int fails  = 0;
  int readyMode = 0;
  int accCount = 0;
  int accSum = 0;
  bit toggleBit = 1'b0;

  // reference model state
  bit mIdle = 1'b1, mValid = 1'b0, mDone = 1'b0, mGap = 1'b0;
  int mRem = 0, mVl = 0, mVmax = 0, mSz = 0;
  logic [ADDR_W-1:0] mA = '0, mB = '0, mD = '0;

  // stall snapshot
  bit stalled = 1'b0;
  logic [VL_W-1:0]   sVl;
  logic [ADDR_W-1:0] sA, sB, sD;

  always #(CLK_PERIOD/2) clk = ~clk;

  stripSeq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .VL_W(VL_W)) i_stripSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .totalCount(totalCount),
    .srcABase(srcABase), .srcBBase(srcBBase), .dstBase(dstBase),
    .vlMax(vlMax), .sizeCode(sizeCode), .idle(idle), .passValid(passValid),
    .passReady(passReady), .passVl(passVl), .passSrcA(passSrcA),
    .passSrcB(passSrcB), .passDst(passDst), .doneOut(doneOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    stalled = rstN && passValid && !passReady;
    sVl = passVl; sA = passSrcA; sB = passSrcB; sD = passDst;
    if (rstN && passValid && passReady) begin
      accCount++;
      accSum += int'(passVl);
    end
    if (!rstN) begin
      mIdle = 1; mValid = 0; mDone = 0; mGap = 0;
    end else if (mDone) begin
      mDone = 0; mIdle = 1;
    end else if (mIdle) begin
      if (startReq) begin
        mIdle = 0;
        mRem = int'(totalCount); mVmax = int'(vlMax); mSz = int'(sizeCode);
        mA = srcABase; mB = srcBBase; mD = dstBase;
        if (mRem == 0) mDone = 1; else mGap = 1;
      end
    end else if (mGap) begin
      mVl = (mRem < mVmax) ? mRem : mVmax;
      mValid = 1; mGap = 0;
    end else if (mValid && passReady) begin
      int step;
      step = mVl * (1 << mSz);
      mRem -= mVl;
      mA = mA + ADDR_W'(step); mB = mB + ADDR_W'(step); mD = mD + ADDR_W'(step);
      mValid = 0;
      if (mRem == 0) mDone = 1; else mGap = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 idle", idle, mIdle);
      chk("R8 passValid", passValid, mValid);
      chk("R7 doneOut", doneOut, mDone);
      if (mValid && passValid) begin
        chk("R2 passVl", passVl, mVl);
        chk("R4 passSrcA", passSrcA, mA);
        chk("R4 passSrcB", passSrcB, mB);
        chk("R4 passDst", passDst, mD);
      end
      if (stalled) begin
        chk("R5 hold valid", passValid, 1);
        chk("R5 hold vl", passVl, sVl);
        chk("R5 hold srcA", passSrcA, sA);
        chk("R5 hold srcB", passSrcB, sB);
        chk("R5 hold dst", passDst, sD);
      end
    end
  end

  // ready pattern driver
  always @(negedge clk) begin
    toggleBit = ~toggleBit;
    case (readyMode)
      0:       passReady = 1'b1;
      1:       passReady = 1'($urandom_range(0, 1));
      default: passReady = toggleBit;
    endcase
  end

  task automatic runJob(input int cnt, input int vmax, input int sz,
                        input logic [ADDR_W-1:0] baseA,
                        input logic [ADDR_W-1:0] baseB,
                        input logic [ADDR_W-1:0] baseD,
                        input bit holdStart, input int rmode);
    @(negedge clk);
    readyMode = rmode;
    accCount = 0; accSum = 0;
    totalCount = CNT_W'(cnt); vlMax = VL_W'(vmax); sizeCode = 2'(sz);
    srcABase = baseA; srcBBase = baseB; dstBase = baseD;
    startReq = 1'b1;
    @(negedge clk);
    if (!holdStart) startReq = 1'b0;
    // R1: scramble inputs while busy
    totalCount = 16'hFFFF; vlMax = 8'd3; sizeCode = 2'd1; srcABase = 32'hDEAD0000;
    while (!doneOut) @(negedge clk);
    startReq = 1'b0;
    chk("R3 pass count", accCount, (cnt + vmax - 1) / vmax);
    chk("R3 length sum", accSum, cnt);
    @(negedge clk);
    chk("R7 idle after done", idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset idle", idle, 1);
    chk("R1 reset valid", passValid, 0);
    chk("R1 reset done", doneOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 example: 6 with capacity 4 -> 4 then 2
    runJob(6, 4, 2, 32'h1000, 32'h2000, 32'h3000, 0, 0);
    // R6 zero count
    runJob(0, 4, 2, 32'h1000, 32'h2000, 32'h3000, 0, 0);
    chk("R6 no descriptor", accCount, 0);
    // R4 byte elements, random ready
    runJob(17, 5, 0, 32'h0000_0010, 32'h0000_0100, 32'h0000_1000, 0, 1);
    // R4 8-byte elements, single short pass
    runJob(3, 8, 3, 32'h8000, 32'h9000, 32'hA000, 0, 2);
    // R1 start held high and inputs scrambled while busy
    runJob(20, 4, 1, 32'h40, 32'h80, 32'hC0, 1, 1);
    // large capacity and count
    runJob(300, 255, 3, 32'hFFFF_F000, 32'h0, 32'h10_0000, 0, 2);
    // exact multiple of capacity
    runJob(12, 4, 2, 32'h100, 32'h200, 32'h300, 0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule